// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block sits between a clocked host and an external asynchronous static RAM of 512K words by 16 bits. The host offers one single-word request at a time on a valid/ready port. Each request carries a word address, write data, a two-bit byte mask and a direction flag. The controller then runs the memory's active-low chip select, write enable, output enable and two byte strobes for a fixed number of clocks. It also drives the shared data bus through a separate output-enable line. A read returns its data on a one-clock response pulse.

Every minimum time of the memory is given in nanoseconds and turned into a clock count by rounding up against the clock period:

- Read access time.
- Write pulse width.
- Address-to-end-of-write time.
- Data setup to end of write.
- Write cycle time.

A write keeps output enable high for its whole length. Chip select, the byte strobes and write enable fall together, so the memory's outputs stay floating while the controller drives the bus. After every read, one spare clock lets the memory release the bus before any further access can start.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is high and on the first clock after it, every memory strobe is high, the data drivers are off, `req_ready` is high and `rsp_valid` is low.
- R2: A read holds chip select, output enable and the enabled byte strobes low, with write enable high, for RD_CYC = ceil(T_ACC_NS / CLK_NS) clocks (6 by default). The data bus is sampled on the last of those clocks. `rsp_valid` is high for exactly one clock, the clock that follows the last access clock.
- R3: `req_be[0]` gates `mem_lb_n` and data bits 7:0, and `req_be[1]` gates `mem_ub_n` and bits 15:8. A write changes only the enabled bytes. A read returns zero in every byte lane that is not enabled.
- R4: A write holds chip select, write enable and the enabled byte strobes low together for WP_CYC clocks (5 by default). WP_CYC is the largest of the rounded-up write pulse, address-to-end and data-setup times. Output enable stays high throughout, and `mem_dq_oe` is high exactly while write enable is low.
- R5: After the write pulse, all strobes stay high for max(WC_CYC − WP_CYC, 0) clocks (1 by default) before `req_ready` returns. WC_CYC is the rounded-up write cycle time.
- R6: After each read, one clock with all strobes high and `req_ready` low passes before the controller accepts a new request.
- R7: `req_ready` is low from the clock after a request is accepted until the cycle, including its recovery or turnaround clock, is over. Requests presented while `req_ready` is low are ignored.
- R8: Address, byte strobes and write data on the memory side stay constant for the whole cycle, even if the host changes its request inputs meanwhile.
- R9: A request with `req_be` = 0 asserts neither byte strobe and leaves the memory unchanged. A read with that mask returns 0.
- R10: A read cycle lasts RD_CYC + 1 clocks and a write cycle lasts WP_CYC + max(WC_CYC − WP_CYC, 0) clocks. Both are counted from acceptance until `req_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-clock read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low byte strobe, active low |
| mem_ub_n | output | 1 | High byte strobe, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enables the controller's data drivers |
| mem_dq_in | input | 16 | Data bus as seen from the memory |

## Verification
The assertions watch the strobe protocol on every clock:

- Output enable and write enable are never low together.
- The controller drives the bus only during the write pulse.
- Write-pulse and read-access lengths match their derived counts.
- The address holds while the chip is selected.
- The response is a single pulse.
- A turnaround clock follows every read.

Only the bench's scenarios can show the data-dependent behaviour: byte-lane merging in the memory, zeroing of disabled lanes, mask-zero requests that leave contents unchanged, and requests ignored while the controller is busy. It also confirms that the memory never drives the bus during a write.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

    localparam int ADDR_W = 19;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_TURN,
        PH_WRITE,
        PH_RECOVER
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be;
    } req_t;

    function automatic int ns_to_cyc(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_port_pkg::*;
#(
    parameter int RD_CYC  = 6,
    parameter int WP_CYC  = 5,
    parameter int REC_CYC = 1,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             acc_wr,
    input  logic             tmr_zero,
    output phase_e           phase,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);
    phase_e phase_q, phase_d;

    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    if (acc_wr) begin
                        phase_d = PH_WRITE;
                        tmr_val = CNT_W'(WP_CYC - 1);
                    end else begin
                        phase_d = PH_READ;
                        tmr_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            PH_READ: begin
                if (tmr_zero) phase_d = PH_TURN;
            end
            PH_TURN: begin
                phase_d = PH_IDLE;
            end
            PH_WRITE: begin
                if (tmr_zero) begin
                    if (REC_CYC > 0) begin
                        phase_d  = PH_RECOVER;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(imax(REC_CYC - 1, 0));
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end
            end
            PH_RECOVER: begin
                if (tmr_zero) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/sram_rd_lanes.sv
module sram_rd_lanes
    import sram_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                rdata[8*l +: 8] <= '0;
            else if (capture)
                rdata[8*l +: 8] <= lane_en[l] ? bus_in[8*l +: 8] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rvalid <= 1'b0;
        else     rvalid <= capture;
    end
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
    import sram_port_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int T_ACC_NS = 55,
    parameter int T_WP_NS  = 45,
    parameter int T_AW_NS  = 50,
    parameter int T_DS_NS  = 25,
    parameter int T_WC_NS  = 55
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int RD_CYC  = imax(ns_to_cyc(T_ACC_NS, CLK_NS), 1);
    localparam int WP_CYC  = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                       ns_to_cyc(T_AW_NS, CLK_NS)),
                                  imax(ns_to_cyc(T_DS_NS, CLK_NS), 1));
    localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int REC_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 0;
    localparam int CNT_W   = $clog2(imax(imax(RD_CYC, WP_CYC), REC_CYC) + 1);

    phase_e           phase;
    req_t             cur_q;
    logic             accept;
    logic             tmr_zero;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             active;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else if (accept)
            cur_q <= '{wr: req_write, addr: req_addr, wdata: req_wdata, be: req_be};
    end

    sram_seq_fsm #(
        .RD_CYC (RD_CYC),
        .WP_CYC (WP_CYC),
        .REC_CYC(REC_CYC),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .acc_wr  (req_write),
        .tmr_zero(tmr_zero),
        .phase   (phase),
        .tmr_load(tmr_load),
        .tmr_val (tmr_val)
    );

    sram_phase_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    sram_rd_lanes u_lanes (
        .clk    (clk),
        .rst    (rst),
        .capture((phase == PH_READ) && tmr_zero),
        .lane_en(cur_q.be),
        .bus_in (mem_dq_in),
        .rdata  (rsp_rdata),
        .rvalid (rsp_valid)
    );

    // Strobe decode: select, byte strobes and write enable fall together on a write.
    always_comb begin
        active     = (phase == PH_READ) || (phase == PH_WRITE);
        mem_addr   = cur_q.addr;
        mem_cs_n   = !active;
        mem_oe_n   = (phase != PH_READ);
        mem_we_n   = (phase != PH_WRITE);
        mem_lb_n   = !(active && cur_q.be[0]);
        mem_ub_n   = !(active && cur_q.be[1]);
        mem_dq_oe  = (phase == PH_WRITE);
        mem_dq_out = cur_q.wdata;
    end
endmodule

// File: rtl/sram_port_chk.sv
module sram_port_chk #(
    parameter int RD_CYC = 6,
    parameter int WP_CYC = 5
) (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [18:0] mem_addr,
    input logic        mem_cs_n,
    input logic        mem_we_n,
    input logic        mem_oe_n,
    input logic        mem_dq_oe
);
    logic [7:0] we_run, oe_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_run <= '0;
            oe_run <= '0;
        end else begin
            we_run <= mem_we_n ? 8'd0 : we_run + 8'd1;
            oe_run <= mem_oe_n ? 8'd0 : oe_run + 8'd1;
        end
    end

    a_r4_no_oe_in_write: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);
    a_r4_drive_only_in_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && !mem_cs_n));
    a_r4_pulse_length: assert property (@(posedge clk) disable iff (rst)
        (mem_we_n && we_run != 8'd0) |-> (we_run == 8'(WP_CYC)));
    a_r2_access_length: assert property (@(posedge clk) disable iff (rst)
        (mem_oe_n && oe_run != 8'd0) |-> (oe_run == 8'(RD_CYC)));
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    a_r6_turnaround: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (mem_cs_n && !req_ready));
    a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> !req_ready);
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |=> (mem_cs_n || $stable(mem_addr)));
endmodule

bind sram_port_ctrl sram_port_chk #(
    .RD_CYC(RD_CYC),
    .WP_CYC(WP_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_port_ctrl_bench.sv
module sram_port_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out, mem_dq_in;

    int checks = 0, fails = 0;
    logic [15:0] mem [256];
    logic rd_act;

    always #5 clk = ~clk;

    sram_port_ctrl u_sram_port_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: drives only while a read is active, latches bytes during write.
    assign rd_act = !mem_cs_n && mem_we_n && !mem_oe_n && !(mem_lb_n && mem_ub_n);
    assign mem_dq_in = rd_act
        ? {mem_ub_n ? 8'h00 : mem[mem_addr[7:0]][15:8], mem_lb_n ? 8'h00 : mem[mem_addr[7:0]][7:0]}
        : (mem_dq_oe ? mem_dq_out : 16'h0000);

    always @(negedge clk) begin
        if (!rst && !mem_cs_n && !mem_we_n) begin
            if (!mem_lb_n) mem[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) mem[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [18:0] addr;
        logic [15:0] data;
        logic [1:0]  be;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 19'h00010, 16'hA5C3, 2'b11, 16'h0000},
        '{1'b0, 19'h00010, 16'h0000, 2'b11, 16'hA5C3},
        '{1'b1, 19'h7FF22, 16'h1234, 2'b01, 16'h0000},
        '{1'b0, 19'h7FF22, 16'h0000, 2'b11, 16'h0034},
        '{1'b1, 19'h7FF22, 16'hABCD, 2'b10, 16'h0000},
        '{1'b0, 19'h7FF22, 16'h0000, 2'b11, 16'hAB34},
        '{1'b0, 19'h7FF22, 16'h0000, 2'b01, 16'h0034},
        '{1'b0, 19'h7FF22, 16'h0000, 2'b10, 16'hAB00},
        '{1'b1, 19'h00010, 16'hFFFF, 2'b00, 16'h0000},
        '{1'b0, 19'h00010, 16'h0000, 2'b11, 16'hA5C3},
        '{1'b0, 19'h00010, 16'h0000, 2'b00, 16'h0000},
        '{1'b1, 19'h40001, 16'h5A5A, 2'b11, 16'h0000},
        '{1'b0, 19'h40001, 16'h0000, 2'b11, 16'h5A5A},
        '{1'b1, 19'h40001, 16'h9999, 2'b11, 16'h0000},
        '{1'b0, 19'h40001, 16'h0000, 2'b11, 16'h9999}
    };

    // Runs one request; hold=1 keeps req_valid high and scrambles the request while busy.
    task automatic run_op(input vec_t v, input bit hold);
        int busy = 0, cs_lo = 0, oe_lo = 0, we_lo = 0, drv = 0, lb_lo = 0, ub_lo = 0;
        int bad_addr = 0, clash = 0, resp = 0, we_falls = 0;
        logic prev_we = 1'b1;
        logic [15:0] got = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_addr = v.addr;
        req_wdata = v.data; req_be = v.be;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        forever begin
            @(negedge clk);
            if (hold) begin
                req_addr = v.addr ^ 19'h00005; req_wdata = ~v.data;
            end else begin
                req_valid = 1'b0;
            end
            if (req_ready) break;
            busy++;
            if (!mem_cs_n) begin
                cs_lo++;
                if (mem_addr != v.addr) bad_addr++;
            end
            if (!mem_oe_n) oe_lo++;
            if (!mem_we_n) we_lo++;
            if (!mem_we_n && prev_we) we_falls++;
            prev_we = mem_we_n;
            if (mem_dq_oe) begin
                drv++;
                if (mem_dq_out != v.data) bad_addr++;
            end
            if (!mem_lb_n) lb_lo++;
            if (!mem_ub_n) ub_lo++;
            if ((rd_act && mem_dq_oe) || (!mem_we_n && !mem_oe_n)) clash++;
            if (rsp_valid) begin resp++; got = rsp_rdata; end
        end
        req_valid = 1'b0;
        check(bad_addr == 0, "R8 address/data held", bad_addr, 0);
        check(clash == 0, "R4 no bus clash", clash, 0);
        check(mem_oe_n && mem_we_n && mem_cs_n, "R10 strobes idle after cycle", {mem_cs_n, mem_we_n, mem_oe_n}, 7);
        if (v.wr) begin
            check(busy == 6, "R5 R10 write busy clocks", busy, 6);
            check(we_lo == 5 && cs_lo == 5, "R4 write pulse clocks", we_lo, 5);
            check(we_falls == 1, "R7 single write pulse", we_falls, 1);
            check(oe_lo == 0, "R4 oe high in write", oe_lo, 0);
            check(drv == we_lo, "R4 drivers follow we", drv, we_lo);
            check(resp == 0, "R2 no response on write", resp, 0);
        end else begin
            check(busy == 7, "R6 R10 read busy clocks", busy, 7);
            check(cs_lo == 6 && oe_lo == 6 && we_lo == 0, "R2 read access clocks", oe_lo, 6);
            check(resp == 1, "R2 one response pulse", resp, 1);
            check(got == v.exp, "R3 R9 read data", got, v.exp);
        end
        check(lb_lo == (v.be[0] ? cs_lo : 0), "R3 R9 low strobe", lb_lo, v.be[0] ? cs_lo : 0);
        check(ub_lo == (v.be[1] ? cs_lo : 0), "R3 R9 high strobe", ub_lo, v.be[1] ? cs_lo : 0);
    endtask

    task automatic idle_check(input string tag);
        check(req_ready && mem_cs_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n
              && !mem_dq_oe && !rsp_valid, tag,
              {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_valid},
              8'hFC);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        idle_check("R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        idle_check("R1 after reset");

        for (int i = 0; i < NV; i++) run_op(VECS[i], 1'b0);

        // R7 R8: request held and scrambled while busy is taken once with original values.
        run_op('{1'b1, 19'h00033, 16'hC0DE, 2'b11, 16'h0000}, 1'b1);
        run_op('{1'b0, 19'h00033, 16'h0000, 2'b11, 16'hC0DE}, 1'b0);
        check(mem[8'h36] == 16'h0000, "R7 ignored request left memory", mem[8'h36], 0);

        // R1: reset in the middle of a write releases everything.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00050; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        idle_check("R1 mid-cycle reset");
        rst = 1'b0;
        @(negedge clk);
        idle_check("R1 ready after mid-cycle reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule